// File: doc/BRIEF.md
# Card Data FIFO with Width Packing

This block holds the data bytes of a memory-card controller in two byte-wide circular buffers, one per direction. The host side is a register-style port that moves 1, 2 or 4 bytes per access. The card side is a byte stream with a valid/ready handshake. A host write unpacks its word into the transmit buffer, starting with the most significant byte of the access. A host read packs bytes from the receive buffer into a word, placing the first byte in the highest lane of the access.

A transfer begins with a one-cycle start pulse. This pulse is given once the command's response phase has finished. It loads a remaining-byte counter with the product of the block count and the block length, and it latches the direction. Bytes then cross the card side while the counter is nonzero.

When the counter reaches zero, a sticky completion flag is raised. In the card-write direction a second flag, marking that programming is complete, is raised as well. Two service requests tell the host when the receive buffer has data and when the transmit buffer can take more.

Top module: `card_data_fifo`

## Requirements
- R1: After reset, card_tx_valid, card_rx_ready, rx_req, tx_req, data_done, prog_done and host_rd_data are all zero.
- R2: Each buffer holds DEPTH (32) bytes. A host write stops pushing once the transmit buffer is full, and any bytes it has left are dropped. card_rx_ready is low while the receive buffer holds 32 bytes.
- R3: The access width is set by host_size: 00 is 1 byte, 01 is 2 bytes, 10 or 11 is 4 bytes. A host write pushes the bytes of its width most significant first. So a 4-byte write pushes [31:24], [23:16], [15:8], [7:0]; a 2-byte write pushes [15:8] then [7:0]; a 1-byte write pushes [7:0].
- R4: A host read of width N pops up to N bytes. The first byte popped goes to lane N-1, where lane k is bits [8k+7:8k], and each later byte goes one lane lower. Lanes not filled because the buffer ran empty read zero, and so do lanes at or above N. The result appears on host_rd_data in the cycle after the read and holds until the next read.
- R5: A xfer_start pulse does four things. It loads the remaining count with blk_cnt times blk_len. It latches cfg_write_dir, where 1 means toward the card and 0 means from the card. It clears data_done and prog_done. It takes priority over any byte moving in the same cycle.
- R6: In the card-write direction, card_tx_valid is high while the remaining count is nonzero and the transmit buffer is not empty. card_tx_data shows the oldest byte. Each handshake removes that byte and decrements the count.
- R7: In the card-read direction, card_rx_ready is high while the remaining count is nonzero and the receive buffer has space. Each handshake stores card_rx_data and decrements the count.
- R8: The cycle after the remaining count of an active transfer is zero, data_done is set. prog_done is set with it only for a card-write transfer. Both flags stay set until the next xfer_start. A zero-length transfer completes one cycle after its start.
- R9: rx_req is a registered copy of "the receive buffer is not empty", forced low in the cycle after a host read. tx_req is a registered copy of "card-write direction, count nonzero and the transmit buffer not full", forced low in the cycle after a host write.
- R10: No byte leaves the transmit buffer while the remaining count is zero. Surplus bytes stay queued for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write_dir | input | 1 | Direction for the next start: 1 toward card, 0 from card |
| blk_len | input | 12 | Block length in bytes |
| blk_cnt | input | 16 | Number of blocks |
| xfer_start | input | 1 | Loads the counter and begins a transfer |
| host_size | input | 2 | Host access width code |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 32 | Host write word |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_data | output | 32 | Packed host read word, registered |
| card_tx_data | output | 8 | Byte toward the card |
| card_tx_valid | output | 1 | card_tx_data is valid |
| card_tx_ready | input | 1 | Card accepts the byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | card_rx_data is valid |
| card_rx_ready | output | 1 | Block accepts a card byte |
| rx_req | output | 1 | Receive buffer needs service |
| tx_req | output | 1 | Transmit buffer can take data |
| data_done | output | 1 | Transfer complete, sticky |
| prog_done | output | 1 | Card-write transfer complete, sticky |

## Verification
The assertions assume that xfer_start is a single-cycle pulse. They also assume that the card holds its ready low only as a stall, without ever retracting a handshake half-way, so a stalled transmit byte must stay put. card_tx_data is taken to carry meaning only while card_tx_valid is high. The stimulus drives every input half a cycle away from the sampling edge and pulses the start strobe for one cycle only. It also lets the receive side stall on a full buffer, so that back-pressure is exercised without breaking these assumptions.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  // Host word is four byte lanes wide
  localparam int HOST_LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } host_size_e;

  // Number of bytes moved by one host access
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cdf_ring.sv
// Circular byte buffer with a multi-lane push port and a multi-lane peek/pop port.
// DEPTH must be a power of two. Callers keep push_cnt within free space and
// pop_cnt within level, both measured at the start of the cycle.
module cdf_ring #(
  parameter int DEPTH      = 32,
  parameter int PUSH_LANES = 1,
  parameter int POP_LANES  = 1,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LW-1:0]               push_cnt,
  input  logic [PUSH_LANES-1:0][7:0]  push_data,
  input  logic [LW-1:0]               pop_cnt,
  output logic [POP_LANES-1:0][7:0]   peek_data,
  output logic [LW-1:0]               level
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] head_q;
  logic [LW-1:0] level_q;
  logic [PW-1:0] tail;

  assign tail  = head_q + level_q[PW-1:0];
  assign level = level_q;

  // storage: no reset so it can map onto plain memory cells
  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_LANES; i++) begin
      if (LW'(i) < push_cnt) mem[PW'(tail + PW'(i))] <= push_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      level_q <= '0;
    end else begin
      head_q  <= head_q + pop_cnt[PW-1:0];
      level_q <= level_q + push_cnt - pop_cnt;
    end
  end

  generate
    for (genvar j = 0; j < POP_LANES; j++) begin : g_peek
      assign peek_data[j] = mem[PW'(head_q + PW'(j))];
    end
  endgenerate
endmodule

// File: rtl/cdf_host_pack.sv
// Host-side width conversion: unpacks writes into the TX ring, packs reads
// from the RX ring into a registered word.
module cdf_host_pack
  import cdf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int DW = 8 * HOST_LANES
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  host_size,
  input  logic                        host_wr_en,
  input  logic [DW-1:0]               host_wr_data,
  input  logic                        host_rd_en,
  output logic [DW-1:0]               host_rd_data,
  input  logic [LW-1:0]               tx_level,
  input  logic [LW-1:0]               rx_level,
  input  logic [HOST_LANES-1:0][7:0]  rx_peek,
  output logic [LW-1:0]               tx_push_cnt,
  output logic [HOST_LANES-1:0][7:0]  tx_push_data,
  output logic [LW-1:0]               rx_pop_cnt
);
  int            nb;
  int            wr_n;
  int            rd_n;
  logic [DW-1:0] wr_top;
  logic [DW-1:0] rd_top;
  logic [DW-1:0] rd_next;
  logic [LW-1:0] tx_space;

  assign tx_space = LW'(DEPTH) - tx_level;

  always_comb begin
    nb     = int'(size_bytes(host_size));
    // write: align the access so its top lane sits at the word's top
    wr_n   = host_wr_en ? ((nb < int'(tx_space)) ? nb : int'(tx_space)) : 0;
    wr_top = host_wr_data << (8 * (HOST_LANES - nb));
    for (int i = 0; i < HOST_LANES; i++) begin
      tx_push_data[i] = wr_top[8*(HOST_LANES-1-i) +: 8];
    end
    tx_push_cnt = LW'(wr_n);
    // read: first byte to the top, then shift down to the access width
    rd_n   = host_rd_en ? ((nb < int'(rx_level)) ? nb : int'(rx_level)) : 0;
    rd_top = '0;
    for (int i = 0; i < HOST_LANES; i++) begin
      if (i < rd_n) rd_top[8*(HOST_LANES-1-i) +: 8] = rx_peek[i];
    end
    rd_next    = rd_top >> (8 * (HOST_LANES - nb));
    rx_pop_cnt = LW'(rd_n);
  end

  always_ff @(posedge clk) begin
    if (rst)             host_rd_data <= '0;
    else if (host_rd_en) host_rd_data <= rd_next;
  end
endmodule

// File: rtl/cdf_xfer_ctl.sv
// Remaining-byte counter, card-side handshakes, service requests and
// completion flags.
module cdf_xfer_ctl #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int REM_W = LEN_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_start,
  input  logic             cfg_write_dir,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    rx_level,
  input  logic             host_rd_en,
  input  logic             host_wr_en,
  input  logic             card_tx_ready,
  input  logic             card_rx_valid,
  output logic             card_tx_valid,
  output logic             card_rx_ready,
  output logic [LW-1:0]    tx_pop_cnt,
  output logic [LW-1:0]    rx_push_cnt,
  output logic             rx_req,
  output logic             tx_req,
  output logic             data_done,
  output logic             prog_done
);
  logic [REM_W-1:0] rem_q;
  logic             active_q;
  logic             dir_q;
  logic             rx_req_q;
  logic             tx_req_q;
  logic             done_q;
  logic             prog_q;
  logic             has_rem;
  logic             tx_fire;
  logic             rx_fire;

  assign has_rem       = (rem_q != '0);
  assign card_tx_valid = has_rem & dir_q & (tx_level != '0);
  assign card_rx_ready = has_rem & ~dir_q & (rx_level < LW'(DEPTH));
  assign tx_fire       = card_tx_valid & card_tx_ready;
  assign rx_fire       = card_rx_ready & card_rx_valid;
  assign tx_pop_cnt    = {{(LW-1){1'b0}}, tx_fire};
  assign rx_push_cnt   = {{(LW-1){1'b0}}, rx_fire};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      rx_req_q <= 1'b0;
      tx_req_q <= 1'b0;
      done_q   <= 1'b0;
      prog_q   <= 1'b0;
    end else begin
      // an access clears its request; the level is looked at again next cycle
      rx_req_q <= ~host_rd_en & (rx_level != '0);
      tx_req_q <= ~host_wr_en & has_rem & dir_q & (tx_level < LW'(DEPTH));
      if (xfer_start) begin
        rem_q    <= REM_W'(blk_cnt) * REM_W'(blk_len);
        active_q <= 1'b1;
        dir_q    <= cfg_write_dir;
        done_q   <= 1'b0;
        prog_q   <= 1'b0;
      end else begin
        if (tx_fire | rx_fire) rem_q <= rem_q - 1'b1;
        if (active_q && !has_rem) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          prog_q   <= dir_q;
        end
      end
    end
  end

  assign rx_req    = rx_req_q;
  assign tx_req    = tx_req_q;
  assign data_done = done_q;
  assign prog_done = prog_q;
endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo
  import cdf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int DW = 8 * HOST_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_write_dir,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             xfer_start,
  input  logic [1:0]       host_size,
  input  logic             host_wr_en,
  input  logic [DW-1:0]    host_wr_data,
  input  logic             host_rd_en,
  output logic [DW-1:0]    host_rd_data,
  output logic [7:0]       card_tx_data,
  output logic             card_tx_valid,
  input  logic             card_tx_ready,
  input  logic [7:0]       card_rx_data,
  input  logic             card_rx_valid,
  output logic             card_rx_ready,
  output logic             rx_req,
  output logic             tx_req,
  output logic             data_done,
  output logic             prog_done
);
  logic [LW-1:0]              tx_level;
  logic [LW-1:0]              rx_level;
  logic [LW-1:0]              tx_push_cnt;
  logic [LW-1:0]              tx_pop_cnt;
  logic [LW-1:0]              rx_push_cnt;
  logic [LW-1:0]              rx_pop_cnt;
  logic [HOST_LANES-1:0][7:0] tx_push_data;
  logic [HOST_LANES-1:0][7:0] rx_peek;
  logic [0:0][7:0]            tx_peek;
  logic [0:0][7:0]            rx_push_data;

  assign rx_push_data[0] = card_rx_data;
  assign card_tx_data    = tx_peek[0];

  cdf_ring #(.DEPTH(DEPTH), .PUSH_LANES(HOST_LANES), .POP_LANES(1)) u_tx_ring (
    .clk       (clk),
    .rst       (rst),
    .push_cnt  (tx_push_cnt),
    .push_data (tx_push_data),
    .pop_cnt   (tx_pop_cnt),
    .peek_data (tx_peek),
    .level     (tx_level)
  );

  cdf_ring #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(HOST_LANES)) u_rx_ring (
    .clk       (clk),
    .rst       (rst),
    .push_cnt  (rx_push_cnt),
    .push_data (rx_push_data),
    .pop_cnt   (rx_pop_cnt),
    .peek_data (rx_peek),
    .level     (rx_level)
  );

  cdf_host_pack #(.DEPTH(DEPTH)) u_pack (
    .clk          (clk),
    .rst          (rst),
    .host_size    (host_size),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .rx_peek      (rx_peek),
    .tx_push_cnt  (tx_push_cnt),
    .tx_push_data (tx_push_data),
    .rx_pop_cnt   (rx_pop_cnt)
  );

  cdf_xfer_ctl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctl (
    .clk           (clk),
    .rst           (rst),
    .xfer_start    (xfer_start),
    .cfg_write_dir (cfg_write_dir),
    .blk_len       (blk_len),
    .blk_cnt       (blk_cnt),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .host_rd_en    (host_rd_en),
    .host_wr_en    (host_wr_en),
    .card_tx_ready (card_tx_ready),
    .card_rx_valid (card_rx_valid),
    .card_tx_valid (card_tx_valid),
    .card_rx_ready (card_rx_ready),
    .tx_pop_cnt    (tx_pop_cnt),
    .rx_push_cnt   (rx_push_cnt),
    .rx_req        (rx_req),
    .tx_req        (tx_req),
    .data_done     (data_done),
    .prog_done     (prog_done)
  );
endmodule

// File: rtl/card_data_fifo_chk.sv
module card_data_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          xfer_start,
  input logic          host_rd_en,
  input logic          host_wr_en,
  input logic          card_tx_valid,
  input logic          card_tx_ready,
  input logic [7:0]    card_tx_data,
  input logic          card_rx_ready,
  input logic          rx_req,
  input logic          tx_req,
  input logic          data_done,
  input logic          prog_done,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  // R2
  full_stalls_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_level == LW'(DEPTH)) |-> !card_rx_ready);

  // R5
  start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> (!data_done && !prog_done));

  // R6
  tx_stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (card_tx_valid && !card_tx_ready && !xfer_start) |=>
      (card_tx_valid && $stable(card_tx_data)));

  // R7
  one_direction_chk: assert property (@(posedge clk) disable iff (rst)
    !(card_tx_valid && card_rx_ready));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (data_done && !xfer_start) |=> data_done);

  // R8
  prog_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> data_done);

  // R9
  rx_req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd_en |=> !rx_req);

  // R9
  tx_req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr_en |=> !tx_req);
endmodule

bind card_data_fifo card_data_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .xfer_start    (xfer_start),
  .host_rd_en    (host_rd_en),
  .host_wr_en    (host_wr_en),
  .card_tx_valid (card_tx_valid),
  .card_tx_ready (card_tx_ready),
  .card_tx_data  (card_tx_data),
  .card_rx_ready (card_rx_ready),
  .rx_req        (rx_req),
  .tx_req        (tx_req),
  .data_done     (data_done),
  .prog_done     (prog_done),
  .tx_level      (tx_level),
  .rx_level      (rx_level)
);

// File: tb/card_data_fifo_tb_top.sv
`timescale 1ns/1ps
module card_data_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_write_dir = 1'b0;
  logic [11:0] blk_len = '0;
  logic [15:0] blk_cnt = '0;
  logic        xfer_start = 1'b0;
  logic [1:0]  host_size = 2'b10;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic        host_rd_en = 1'b0;
  logic [31:0] host_rd_data;
  logic [7:0]  card_tx_data;
  logic        card_tx_valid;
  logic        card_tx_ready = 1'b0;
  logic [7:0]  card_rx_data = '0;
  logic        card_rx_valid = 1'b0;
  logic        card_rx_ready;
  logic        rx_req, tx_req, data_done, prog_done;

  always #4 clk = ~clk;  // 125 MHz

  card_data_fifo dut_i (.*);

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0]  m_tx[$];
  logic [7:0]  m_rx[$];
  longint      m_rem = 0;
  bit          m_act = 0, m_dir = 0, m_done = 0, m_prog = 0, m_rxreq = 0, m_txreq = 0;
  logic [31:0] m_rd = '0;
  int          rx_src = 0;
  logic [7:0]  sent_q[$];

  function automatic logic [7:0] src_byte(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural model, advanced on each rising edge from pre-edge state
  always @(posedge clk) begin : model
    int txs, rxs, n, k;
    longint r;
    bit tv, rr;
    logic [31:0] w;
    if (rst) begin
      m_tx.delete(); m_rx.delete();
      m_rem = 0; m_act = 0; m_dir = 0; m_done = 0; m_prog = 0;
      m_rxreq = 0; m_txreq = 0; m_rd = '0;
    end else begin
      txs = m_tx.size(); rxs = m_rx.size(); r = m_rem;
      n   = nbytes(host_size);
      tv  = (r != 0) && m_dir && (txs != 0);
      rr  = (r != 0) && !m_dir && (rxs < 32);
      m_rxreq = !host_rd_en && (rxs != 0);
      m_txreq = !host_wr_en && (r != 0) && m_dir && (txs < 32);
      if (host_rd_en) begin
        w = '0;
        k = (n < rxs) ? n : rxs;
        for (int i = 0; i < k; i++) w |= 32'(m_rx.pop_front()) << (8 * (n - 1 - i));
        m_rd = w;
      end
      if (rr && card_rx_valid) begin
        m_rx.push_back(card_rx_data); rx_src++; m_rem--;
      end
      if (tv && card_tx_ready) begin
        void'(m_tx.pop_front()); m_rem--;
      end
      if (host_wr_en) begin
        k = (n < 32 - txs) ? n : 32 - txs;
        for (int i = 0; i < k; i++) m_tx.push_back(host_wr_data[8*(n-1-i) +: 8]);
      end
      if (m_act && r == 0) begin
        m_act = 0; m_done = 1; m_prog = m_dir;
      end
      if (xfer_start) begin
        m_rem = longint'(blk_cnt) * longint'(blk_len);
        m_act = 1; m_dir = cfg_write_dir; m_done = 0; m_prog = 0;
      end
    end
  end

  task automatic compare_all();
    bit ev;
    ev = (m_rem != 0) && m_dir && (m_tx.size() != 0);
    check("R6", "card_tx_valid", 32'(card_tx_valid), 32'(ev));
    if (ev) check("R6", "card_tx_data", 32'(card_tx_data), 32'(m_tx[0]));
    check("R7", "card_rx_ready", 32'(card_rx_ready),
          32'((m_rem != 0) && !m_dir && (m_rx.size() < 32)));
    check("R9", "rx_req", 32'(rx_req), 32'(m_rxreq));
    check("R9", "tx_req", 32'(tx_req), 32'(m_txreq));
    check("R8", "data_done", 32'(data_done), 32'(m_done));
    check("R8", "prog_done", 32'(prog_done), 32'(m_prog));
    check("R4", "host_rd_data", host_rd_data, m_rd);
  endtask

  // entered at a falling edge with the next inputs already applied
  task automatic cyc();
    if (card_tx_valid && card_tx_ready) sent_q.push_back(card_tx_data);
    @(negedge clk);
    if (!rst) compare_all();
    card_rx_data = src_byte(rx_src);
  endtask

  task automatic host_write(input logic [1:0] sz, input logic [31:0] d);
    host_size = sz; host_wr_data = d; host_wr_en = 1'b1;
    cyc();
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sz, output logic [31:0] d);
    host_size = sz; host_rd_en = 1'b1;
    cyc();
    host_rd_en = 1'b0;
    d = host_rd_data;
  endtask

  task automatic start(input bit dir, input int cnt, input int len);
    cfg_write_dir = dir; blk_cnt = 16'(cnt); blk_len = 12'(len); xfer_start = 1'b1;
    cyc();
    xfer_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin : stim
    logic [31:0] d;
    int base;
    @(negedge clk);
    card_rx_data = src_byte(0);
    repeat (3) cyc();
    rst = 1'b0;
    // R1: reset values
    check("R1", "tx_valid", 32'(card_tx_valid), 0);
    check("R1", "rx_ready", 32'(card_rx_ready), 0);
    check("R1", "reqs", {30'd0, rx_req, tx_req}, 0);
    check("R1", "flags", {30'd0, data_done, prog_done}, 0);
    check("R1", "rd_data", host_rd_data, 0);

    // R3: mixed-width unpacking, drained toward the card
    host_write(2'b10, 32'h11223344);
    host_write(2'b01, 32'hAAAA5566);
    host_write(2'b00, 32'hFFFFFF77);
    card_tx_ready = 1'b1;
    sent_q.delete();
    start(1'b1, 1, 7);
    repeat (12) cyc();
    check("R3", "bytes sent", 32'(sent_q.size()), 7);
    if (sent_q.size() == 7)
      check("R3", "order", {sent_q[0], sent_q[1], sent_q[2], sent_q[3]}, 32'h11223344);
    if (sent_q.size() == 7)
      check("R3", "order tail", {8'h0, sent_q[4], sent_q[5], sent_q[6]}, 32'h00556677);
    check("R8", "write done", {30'd0, data_done, prog_done}, 32'h3);

    // R2: overflow of the transmit buffer drops the excess
    for (int i = 0; i < 9; i++) host_write(2'b10, {4{8'(8'h40 + i)}} ^ 32'h00010203);
    sent_q.delete();
    start(1'b1, 2, 20);
    repeat (40) cyc();
    check("R2", "sent before refill", 32'(sent_q.size()), 32);
    check("R2", "last kept byte", 32'(sent_q[31]), 32'(8'h47 ^ 8'h03));
    check("R9", "tx_req with space", 32'(tx_req), 1);
    check("R8", "not done yet", 32'(data_done), 0);
    host_write(2'b10, 32'hD0D1D2D3);
    host_write(2'b10, 32'hE0E1E2E3);
    repeat (12) cyc();
    check("R6", "total sent", 32'(sent_q.size()), 40);
    check("R6", "final byte", 32'(sent_q[39]), 32'hE3);
    check("R8", "done after 40", 32'(data_done), 1);
    card_tx_ready = 1'b0;

    // R4/R7: read direction with packing and zero fill
    base = rx_src;
    card_rx_valid = 1'b1;
    start(1'b0, 2, 5);
    repeat (16) cyc();
    check("R8", "read done", {30'd0, data_done, prog_done}, 32'h2);
    check("R9", "rx_req data waiting", 32'(rx_req), 1);
    host_read(2'b10, d);
    check("R4", "word read", d, {src_byte(base), src_byte(base+1), src_byte(base+2), src_byte(base+3)});
    host_read(2'b01, d);
    check("R4", "half read", d, {16'h0, src_byte(base+4), src_byte(base+5)});
    host_read(2'b00, d);
    check("R4", "byte read", d, {24'h0, src_byte(base+6)});
    host_read(2'b11, d);
    check("R4", "short word read", d, {src_byte(base+7), src_byte(base+8), src_byte(base+9), 8'h00});
    host_read(2'b10, d);
    check("R4", "empty read", d, 0);
    cyc();
    check("R4", "read data holds", host_rd_data, 0);

    // R2/R7: receive buffer fills and stalls the card
    base = rx_src;
    start(1'b0, 1, 40);
    repeat (45) cyc();
    check("R2", "rx stalled when full", 32'(card_rx_ready), 0);
    check("R8", "not done while stalled", 32'(data_done), 0);
    for (int i = 0; i < 10; i++) begin
      host_read(2'b10, d);
      check("R7", "streamed word", d, {src_byte(base+4*i), src_byte(base+4*i+1),
                                     src_byte(base+4*i+2), src_byte(base+4*i+3)});
      repeat (3) cyc();
    end
    check("R8", "done after drain", 32'(data_done), 1);
    card_rx_valid = 1'b0;

    // R8: zero-length transfer
    start(1'b1, 0, 100);
    check("R5", "flags cleared by start", {30'd0, data_done, prog_done}, 0);
    cyc();
    check("R8", "zero length done", {30'd0, data_done, prog_done}, 32'h3);

    // R10: surplus bytes wait for the next transfer
    host_write(2'b10, 32'hC1C2C3C4);
    card_tx_ready = 1'b1;
    sent_q.delete();
    start(1'b1, 1, 2);
    repeat (6) cyc();
    check("R10", "first part sent", 32'(sent_q.size()), 2);
    check("R10", "no send at zero count", 32'(card_tx_valid), 0);
    start(1'b1, 1, 2);
    repeat (6) cyc();
    check("R5", "second start resumes", 32'(sent_q.size()), 4);
    if (sent_q.size() == 4)
      check("R10", "surplus order", {sent_q[2], sent_q[3]}, 32'h0000C3C4);
    repeat (4) cyc();
    finish_run();
  end
endmodule